// File: doc/BRIEF.md
# Flash Operation Interrupt Status Register

This block holds the interrupt status of a NAND-style flash controller. It keeps three pending flags, one each for completion of a program operation, an erase operation and a reset operation. The command sequencer reports each finished operation with a one-cycle strobe and the 16-bit command code that ran. A flag sets only when the code is one of the codes listed for that flag. The host reads the flags through a 16-bit status word. It clears them by writing zeros. When auto-clear mode is on, the flags also clear whenever a new command is written to the command register.

Three synchronous, active-high resets act on the flags. A cold reset brings every flag to zero. A warm or hot reset clears the program and erase flags and forces the reset flag to one. When a warm reset is released, that release counts as a completed reset. A single interrupt line is high while any flag is pending.

Top module: `flash_irq_status`

## Requirements
- R1: `rd_data` shows the program flag at bit 6, the erase flag at bit 5 and the reset flag at bit 4. Every other bit of `rd_data` reads 0. A flag value of 1 means pending.
- R2: The program flag becomes 1 after a cycle with `done_vld` high and `done_cmd` equal to 16'h0080, 16'h001A, 16'h001B, 16'h007D or 16'h007F.
- R3: The erase flag becomes 1 after a cycle with `done_vld` high and `done_cmd` equal to 16'h0094, 16'h0095 or 16'h0030.
- R4: The reset flag becomes 1 after a cycle with `done_vld` high and `done_cmd` equal to 16'h00B0, 16'h00F0 or 16'h00F3.
- R5: A completion whose code is not in a flag's list leaves that flag unchanged. This includes codes that differ from a listed code by one bit.
- R6: A host write (`reg_wr`) clears each flag whose bit in `reg_wdata` is 0. Writing 1 to a flag bit leaves that flag unchanged.
- R7: With `auto_clr` high, a `cmd_wr` strobe clears all three flags. With `auto_clr` low, `cmd_wr` has no effect.
- R8: A cycle with `rst_cold` high leaves all flags at 0. It overrides every other input in that cycle, including a completion.
- R9: A cycle with `rst_warm` or `rst_hot` high, and `rst_cold` low, leaves the program and erase flags at 0 and the reset flag at 1.
- R10: The first cycle with `rst_warm` low after a cycle with it high sets the reset flag. A host clear in that same cycle does not clear it. A release of `rst_hot` does not set any flag.
- R11: When a flag's set event and a clear event, from a host write or an auto-clear, fall in the same cycle, the flag ends at 1.
- R12: `irq` is 1 exactly when at least one flag is 1, and it updates on the same clock edge as the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_cold | input | 1 | Synchronous cold reset, active high |
| rst_warm | input | 1 | Synchronous warm reset, active high |
| rst_hot | input | 1 | Synchronous hot reset, active high |
| done_vld | input | 1 | Operation completion strobe |
| done_cmd | input | 16 | Command code of the completed operation |
| reg_wr | input | 1 | Host write to the status word |
| reg_wdata | input | 16 | Host write data; a 0 in a flag bit clears that flag |
| cmd_wr | input | 1 | Command register write strobe |
| auto_clr | input | 1 | Auto-clear mode enable |
| rd_data | output | 16 | Status word read by the host |
| irq | output | 1 | Combined interrupt, high while any flag is pending |

## Verification
The flag logic is driven with every listed completion code, and also with codes that differ from a listed one by a single bit. This separates an exact match from a loose one. Host writes use all-ones data, partial zero patterns and all-zero data, which shows that writing 1 never clears a flag and writing 0 always does. Command writes are sent with auto-clear on and with it off.

A set and a clear are placed in the same cycle to show which one has priority. Each reset kind is applied, held, and released with a host clear in the release cycle. This tells a warm release, which sets the reset flag, apart from a hot release, which does not.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

  localparam int CODE_W = 16;
  localparam int WORD_W = 16;

  // flag indices inside the internal flag vector
  localparam int FL_RST = 0;
  localparam int FL_ERS = 1;
  localparam int FL_PGM = 2;
  localparam int FL_N   = 3;

  // bit positions of each flag inside the status word
  localparam int POS_PGM = 6;
  localparam int POS_ERS = 5;
  localparam int POS_RST = 4;

  localparam int N_PGM_CODES = 5;
  localparam int N_ERS_CODES = 3;
  localparam int N_RST_CODES = 3;

  localparam logic [CODE_W-1:0] PGM_CODES [N_PGM_CODES] =
    '{16'h0080, 16'h001A, 16'h001B, 16'h007D, 16'h007F};
  localparam logic [CODE_W-1:0] ERS_CODES [N_ERS_CODES] =
    '{16'h0094, 16'h0095, 16'h0030};
  localparam logic [CODE_W-1:0] RST_CODES [N_RST_CODES] =
    '{16'h00B0, 16'h00F0, 16'h00F3};

endpackage

// File: rtl/irq_code_match.sv
// Compares one completion code against a parameterised list of codes.
module irq_code_match #(
  parameter int CODE_W = 16,
  parameter int N      = 1,
  parameter logic [CODE_W-1:0] CODES [N] = '{default: '0}
) (
  input  logic              vld,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  logic [N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = (code == CODES[i]);
  end

  assign hit = vld & (|eq);
endmodule

// File: rtl/irq_warm_release.sv
// Produces a one-cycle release pulse in the first cycle after a warm reset ends.
module irq_warm_release (
  input  logic clk,
  input  logic rst_cold,
  input  logic rst_warm,
  output logic release_p
);
  logic warm_q;

  always_ff @(posedge clk) begin
    if (rst_cold) warm_q <= 1'b0;
    else          warm_q <= rst_warm;
  end

  assign release_p = warm_q & ~rst_warm & ~rst_cold;
endmodule

// File: rtl/irq_flag_cell.sv
// One pending flag. Priority: cold > warm/hot > set > clear > hold.
module irq_flag_cell #(
  parameter logic SOFT_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_cold,
  input  logic rst_soft,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag_q,
  output logic flag_nxt
);
  always_comb begin
    if (rst_cold)      flag_nxt = 1'b0;
    else if (rst_soft) flag_nxt = SOFT_VAL;
    else if (set_ev)   flag_nxt = 1'b1;
    else if (clr_ev)   flag_nxt = 1'b0;
    else               flag_nxt = flag_q;
  end

  always_ff @(posedge clk) begin
    flag_q <= flag_nxt;
  end
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import flash_irq_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_cold,
  input  logic          rst_warm,
  input  logic          rst_hot,
  input  logic          done_vld,
  input  logic [CW-1:0] done_cmd,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          cmd_wr,
  input  logic          auto_clr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int POS [FL_N] = '{POS_RST, POS_ERS, POS_PGM};

  logic [FL_N-1:0] hit, set_ev, clr_ev, flag_q, flag_nxt;
  logic            warm_rel, rst_soft, auto_hit;
  logic            irq_q;
  logic            unused_wdata_bits;

  irq_code_match #(.CODE_W(CW), .N(N_PGM_CODES), .CODES(PGM_CODES)) u_pgm_match (
    .vld(done_vld), .code(done_cmd), .hit(hit[FL_PGM]));
  irq_code_match #(.CODE_W(CW), .N(N_ERS_CODES), .CODES(ERS_CODES)) u_ers_match (
    .vld(done_vld), .code(done_cmd), .hit(hit[FL_ERS]));
  irq_code_match #(.CODE_W(CW), .N(N_RST_CODES), .CODES(RST_CODES)) u_rst_match (
    .vld(done_vld), .code(done_cmd), .hit(hit[FL_RST]));

  irq_warm_release u_warm_rel (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .release_p(warm_rel));

  assign rst_soft = rst_warm | rst_hot;
  assign auto_hit = cmd_wr & auto_clr;

  for (genvar f = 0; f < FL_N; f++) begin : g_flag
    if (f == FL_RST) begin : g_rst_set
      assign set_ev[f] = hit[f] | warm_rel;
    end else begin : g_op_set
      assign set_ev[f] = hit[f];
    end
    assign clr_ev[f] = (reg_wr & ~reg_wdata[POS[f]]) | auto_hit;

    irq_flag_cell #(.SOFT_VAL(f == FL_RST)) u_cell (
      .clk(clk), .rst_cold(rst_cold), .rst_soft(rst_soft),
      .set_ev(set_ev[f]), .clr_ev(clr_ev[f]),
      .flag_q(flag_q[f]), .flag_nxt(flag_nxt[f]));
  end

  always_ff @(posedge clk) begin
    irq_q <= |flag_nxt;
  end

  always_comb begin
    rd_data = '0;
    for (int f = 0; f < FL_N; f++) rd_data[POS[f]] = flag_q[f];
  end

  assign irq = irq_q;
  assign unused_wdata_bits = ^reg_wdata;
endmodule

// File: rtl/flash_irq_status_chk.sv
module flash_irq_status_chk
  import flash_irq_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int DW = WORD_W
) (
  input logic          clk,
  input logic          rst_cold,
  input logic          rst_warm,
  input logic          rst_hot,
  input logic          done_vld,
  input logic [CW-1:0] done_cmd,
  input logic          reg_wr,
  input logic [DW-1:0] reg_wdata,
  input logic          cmd_wr,
  input logic          auto_clr,
  input logic [DW-1:0] rd_data,
  input logic          irq
);
  localparam logic [DW-1:0] FLAG_MASK = (DW'(1) << POS_PGM) | (DW'(1) << POS_ERS) | (DW'(1) << POS_RST);

  logic live   = 1'b0;
  logic warm_d = 1'b0;
  logic quiet;

  always @(posedge clk) begin
    if (rst_cold) live <= 1'b1;
    warm_d <= rst_warm;
  end

  assign quiet = !rst_cold && !rst_warm && !rst_hot && !warm_d;

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!live)
    (rd_data & ~FLAG_MASK) == '0); // R1
  AST_PGM_SETS: assert property (@(posedge clk) disable iff (!live)
    quiet && done_vld && done_cmd == 16'h0080 |=> rd_data[POS_PGM]); // R2
  AST_ERS_SETS: assert property (@(posedge clk) disable iff (!live)
    quiet && done_vld && done_cmd == 16'h0094 |=> rd_data[POS_ERS]); // R3
  AST_HOST_ONES_KEEP: assert property (@(posedge clk) disable iff (!live)
    quiet && !done_vld && !cmd_wr && reg_wr && reg_wdata[POS_PGM] && reg_wdata[POS_ERS] && reg_wdata[POS_RST]
    |=> $stable(rd_data)); // R6
  AST_AUTO_CLEARS: assert property (@(posedge clk) disable iff (!live)
    quiet && !done_vld && cmd_wr && auto_clr |=> rd_data == '0); // R7
  AST_COLD_ZERO: assert property (@(posedge clk) disable iff (!live)
    rst_cold |=> rd_data == '0 && !irq); // R8
  AST_SOFT_VALUE: assert property (@(posedge clk) disable iff (!live)
    !rst_cold && (rst_warm || rst_hot) |=> rd_data[POS_RST] && !rd_data[POS_PGM] && !rd_data[POS_ERS]); // R9
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!live)
    irq == (rd_data != '0)); // R12
endmodule

bind flash_irq_status flash_irq_status_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .rst_hot(rst_hot),
  .done_vld(done_vld), .done_cmd(done_cmd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .cmd_wr(cmd_wr), .auto_clr(auto_clr), .rd_data(rd_data), .irq(irq));

// File: tb/tb_flash_irq_status.sv
module tb_flash_irq_status;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        dv;
    logic [15:0] cmd;
    logic        rw;
    logic [15:0] wd;
    logic        cw;
    logic        ac;
    logic [2:0]  exp; // {pgm, ers, rst}
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0080, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b100}, // R2
    '{1'b1, 16'h0094, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b110}, // R3
    '{1'b1, 16'h00B0, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b111}, // R4
    '{1'b0, 16'h0000, 1'b1, 16'h0070, 1'b0, 1'b0, 3'b111}, // R6 ones keep
    '{1'b0, 16'h0000, 1'b1, 16'h0030, 1'b0, 1'b0, 3'b011}, // R6 clear pgm
    '{1'b1, 16'h001A, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b111}, // R2
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 3'b111}, // R7 auto off
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 3'b000}, // R7 auto on
    '{1'b1, 16'h0095, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b010}, // R3
    '{1'b1, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b010}, // R5
    '{1'b1, 16'h00F0, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b011}, // R4
    '{1'b0, 16'h0000, 1'b1, 16'h0010, 1'b0, 1'b0, 3'b001}, // R6
    '{1'b1, 16'h001B, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b101}, // R2
    '{1'b1, 16'h0030, 1'b0, 16'h0000, 1'b1, 1'b1, 3'b010}, // R11 with auto clear
    '{1'b1, 16'h007D, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b110}, // R2
    '{1'b1, 16'h00F3, 1'b1, 16'h0000, 1'b0, 1'b0, 3'b001}, // R11 with host clear
    '{1'b1, 16'h007F, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b101}, // R2
    '{1'b1, 16'h0081, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b101}, // R5 near miss
    '{1'b0, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0, 3'b000}, // R6 all zero
    '{1'b1, 16'h00B1, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b000}  // R5 near miss
  };

  logic        clk = 1'b0;
  logic        rst_cold = 1'b0, rst_warm = 1'b0, rst_hot = 1'b0;
  logic        done_vld = 1'b0, reg_wr = 1'b0, cmd_wr = 1'b0, auto_clr = 1'b0;
  logic [15:0] done_cmd = '0, reg_wdata = '0;
  logic [15:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_irq_status dut (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .rst_hot(rst_hot),
    .done_vld(done_vld), .done_cmd(done_cmd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .cmd_wr(cmd_wr), .auto_clr(auto_clr), .rd_data(rd_data), .irq(irq));

  // drive one cycle of inputs at a falling edge, return after the next falling edge
  task automatic cyc(input logic c, input logic w, input logic h, input logic dv,
                     input logic [15:0] cmd, input logic rw, input logic [15:0] wd,
                     input logic cw, input logic ac);
    rst_cold = c; rst_warm = w; rst_hot = h;
    done_vld = dv; done_cmd = cmd; reg_wr = rw; reg_wdata = wd;
    cmd_wr = cw; auto_clr = ac;
    @(negedge clk);
  endtask

  task automatic expect_flags(input string req, input logic [2:0] e);
    logic [15:0] exp_word;
    exp_word = {9'b0, e, 4'b0};
    n_chk++;
    if (rd_data !== exp_word || irq !== (|e)) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
               req, rd_data, irq, exp_word, |e);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1, 0, 0, 0, 16'h0, 0, 16'h0, 0, 0);
    cyc(1, 0, 0, 0, 16'h0, 0, 16'h0, 0, 0);
    expect_flags("R8 after cold reset", 3'b000);

    // table walk: R1 and R12 are checked on every vector via the word layout and irq
    for (int i = 0; i < NV; i++) begin
      cyc(0, 0, 0, VECS[i].dv, VECS[i].cmd, VECS[i].rw, VECS[i].wd, VECS[i].cw, VECS[i].ac);
      expect_flags($sformatf("R1/R12 table vector %0d", i), VECS[i].exp);
    end

    // R9 hot reset, then R10 hot release does not set
    cyc(0, 0, 0, 1, 16'h0080, 0, 16'h0, 0, 0);
    cyc(0, 0, 0, 1, 16'h0094, 0, 16'h0, 0, 0);
    expect_flags("R2 R3 before hot reset", 3'b110);
    cyc(0, 0, 1, 0, 16'h0, 0, 16'h0, 0, 0);
    expect_flags("R9 hot reset value", 3'b001);
    cyc(0, 0, 0, 0, 16'h0, 1, 16'h0, 0, 0);
    expect_flags("R10 hot release sets nothing", 3'b000);

    // R9 warm reset held, then R10 warm release beats host clear
    cyc(0, 0, 0, 1, 16'h0080, 0, 16'h0, 0, 0);
    expect_flags("R2 before warm reset", 3'b100);
    cyc(0, 1, 0, 0, 16'h0, 0, 16'h0, 0, 0);
    expect_flags("R9 warm reset first cycle", 3'b001);
    cyc(0, 1, 0, 1, 16'h0095, 1, 16'h0070, 0, 0);
    expect_flags("R9 warm reset overrides set", 3'b001);
    cyc(0, 0, 0, 0, 16'h0, 1, 16'h0, 0, 0);
    expect_flags("R10 warm release sets reset flag", 3'b001);
    cyc(0, 0, 0, 0, 16'h0, 1, 16'h0, 0, 0);
    expect_flags("R6 clear after warm release", 3'b000);

    // R10 single-cycle warm reset released into an auto-clear
    cyc(0, 1, 0, 0, 16'h0, 0, 16'h0, 0, 0);
    cyc(0, 0, 0, 0, 16'h0, 0, 16'h0, 1, 1);
    expect_flags("R10 warm release beats auto clear", 3'b001);

    // R8 cold reset overrides a completion in the same cycle
    cyc(0, 0, 0, 1, 16'h007F, 0, 16'h0, 0, 0);
    expect_flags("R2 before cold reset", 3'b101);
    cyc(1, 0, 0, 1, 16'h0080, 0, 16'h0, 0, 0);
    expect_flags("R8 cold overrides completion", 3'b000);
    cyc(0, 0, 0, 0, 16'h0, 0, 16'h0, 0, 0);
    expect_flags("R8 stays clear after cold", 3'b000);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule